// File: doc/BRIEF.md
# Serial Register Programming Sequencer

This block loads the configuration registers of an external timing-generator device over a three-wire serial link: a data line, a serial clock and a load strobe. After a start pulse it builds one frame per register, for registers 0 to 7 in turn. Each frame is a write bit, which is always low, then the 4-bit register address sent least significant bit first, then that register's data bits starting with bit 0. The data comes from an internal synchronous table.

Frame content is handled in whole bytes. Each byte goes into an 8-bit parallel-to-serial shift register and leaves one bit per serial clock. Frame lengths are rarely a multiple of eight, so the final byte is filled with don't-care bits. The strobe rises as soon as the exact number of meaningful bits has been sampled, and the serial clock stays still while the strobe is high. The filler bits are therefore never clocked into the device.

Serial data changes only when the serial clock falls, and the device samples it on the rising edge. The serial clock comes from a programmable divider of the system clock. A busy flag covers the whole sequence, and a one-cycle done pulse marks its end.

Top module: `serial_reg_programmer`

## Requirements
- R1: After reset and whenever no sequence is running: busy=0, done=0, ser_load=0, ser_clk=1 (idle high), and ser_data=0 after reset.
- R2: The bits of a frame, in the order the device samples them, are a 0 (write), then address bits A0, A1, A2, A3 of the register number (LSB first), then data bits D0, D1, ... of that register.
- R3: The number of ser_clk rising edges in a frame, counted before ser_load rises, equals 5 plus the register's data-bit count. The data-bit counts for registers 0..7 are 3, 202, 2, 30, 13, 25, 78, 65.
- R4: ser_data changes only in the system-clock cycle in which ser_clk falls.
- R5: Inside a frame, each ser_clk high phase and each low phase lasts DIV system-clock cycles.
- R6: ser_load rises while ser_clk is high, after the last valid bit has been sampled. It stays high for 2*DIV cycles, ser_clk does not toggle while it is high, and it is high only while busy=1.
- R7: At least 2*DIV cycles pass between the fall of ser_load and the first ser_clk fall of the next frame.
- R8: The sequence programs registers 0 through 7 in ascending order, one frame each.
- R9: busy rises in the cycle after start is sampled and stays high until the end. done is a single-cycle pulse, issued once when register 7's strobe falls, and busy is low in that same cycle.
- R10: A start pulse that arrives while busy=1 has no effect on the running sequence or on the frames it sends.
- R11: The data table byte at register r, byte index k holds (r*29 + k*13 + 0x3C) mod 256. Data bit D(n) of register r is bit n mod 8 of byte n/8.
- R12: Pulling rst_n low in the middle of a sequence sets every output to its R1 state at once. A later start runs a complete, correct sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the programming sequence (sampled while idle) |
| busy | output | 1 | High while a sequence is running |
| done | output | 1 | One-cycle pulse when the last register is written |
| ser_clk | output | 1 | Serial clock, idle high |
| ser_data | output | 1 | Serial data, changes on the falling ser_clk edge |
| ser_load | output | 1 | Load strobe that latches the bits shifted so far |

## Verification
The assertions assume that reset is applied before the first start and that DIV is fixed and at least 2. They also assume the checker's own frame counter stays aligned with the block. That holds only if every sequence begins with a start taken while idle, or after a reset. The stimulus follows these rules: start is driven only on falling system-clock edges, and one extra start is deliberately sent in the middle of a running sequence. The one asynchronous reset in the middle of a sequence is followed by a fresh start before any frame is judged.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned REG_W    = $clog2(NUM_REGS);
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned HDR_BITS = 1 + ADDR_W;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned LEN_W    = 8;
  localparam int unsigned IDX_W    = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRIME,
    ST_WAIT,
    ST_SHIFT,
    ST_LATCH,
    ST_GAP
  } seq_state_t;

  // Payload width of each target register.
  function automatic logic [LEN_W-1:0] data_bits(input logic [REG_W-1:0] r);
    case (r)
      3'd0:    data_bits = 8'd3;
      3'd1:    data_bits = 8'd202;
      3'd2:    data_bits = 8'd2;
      3'd3:    data_bits = 8'd30;
      3'd4:    data_bits = 8'd13;
      3'd5:    data_bits = 8'd25;
      3'd6:    data_bits = 8'd78;
      default: data_bits = 8'd65;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(input logic [REG_W-1:0] r);
    frame_len = data_bits(r) + LEN_W'(HDR_BITS);
  endfunction

  // Contents of the configuration table, generated arithmetically.
  function automatic logic [BYTE_W-1:0] rom_byte(input logic [REG_W-1:0] r,
                                                 input logic [IDX_W-1:0] k);
    logic [BYTE_W-1:0] rr;
    logic [BYTE_W-1:0] kk;
    rr = BYTE_W'(r);
    kk = BYTE_W'(k);
    rom_byte = rr * 8'd29 + kk * 8'd13 + 8'h3C;
  endfunction
endpackage

// File: rtl/sps_tick_gen.sv
module sps_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    tick  = run && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sps_rom.sv
module sps_rom
  import sps_pkg::*;
(
  input  logic              clk,
  input  logic              en,
  input  logic [REG_W-1:0]  reg_sel,
  input  logic [IDX_W-1:0]  idx,
  output logic [BYTE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (en) q <= rom_byte(reg_sel, idx);
  end
endmodule

// File: rtl/sps_shifter.sv
module sps_shifter
  import sps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  reg_sel,
  input  logic              prime,
  input  logic              fall,
  input  logic [BYTE_W-1:0] rom_q,
  output logic              rom_en,
  output logic [IDX_W-1:0]  rom_idx,
  output logic              ready,
  output logic              sdata
);
  logic [BYTE_W-1:0]   sr_q, sr_d;
  logic [BYTE_W-1:0]   nxt_q, nxt_d;
  logic [HDR_BITS-1:0] carry_q, carry_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [2:0]          bit_q, bit_d;
  logic                cap_q;
  logic                ready_q, ready_d;
  logic                sdata_q, sdata_d;
  logic [ADDR_W-1:0]   addr_ext;
  logic [BYTE_W-1:0]   assembled;
  logic                byte_end;

  assign addr_ext = ADDR_W'(reg_sel);
  assign byte_end = (bit_q == 3'd7);
  assign rom_en   = prime | (fall & byte_end);
  assign rom_idx  = prime ? '0 : idx_q;

  // Frame byte 0 carries the header; later bytes splice two table bytes.
  always_comb begin
    if (idx_q == '0) assembled = {rom_q[2:0], addr_ext, 1'b0};
    else             assembled = {rom_q[2:0], carry_q};
  end

  always_comb begin
    sr_d    = sr_q;
    nxt_d   = nxt_q;
    carry_d = carry_q;
    idx_d   = idx_q;
    bit_d   = bit_q;
    ready_d = ready_q;
    sdata_d = sdata_q;
    if (prime) begin
      idx_d   = '0;
      bit_d   = 3'd7;
      ready_d = 1'b0;
    end
    if (cap_q) begin
      nxt_d   = assembled;
      carry_d = rom_q[7:3];
      idx_d   = idx_q + 1'b1;
      ready_d = 1'b1;
    end
    if (fall) begin
      if (byte_end) begin
        sdata_d = nxt_q[0];
        sr_d    = {1'b0, nxt_q[BYTE_W-1:1]};
        bit_d   = 3'd0;
      end else begin
        sdata_d = sr_q[0];
        sr_d    = sr_q >> 1;
        bit_d   = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      nxt_q   <= '0;
      carry_q <= '0;
      idx_q   <= '0;
      bit_q   <= 3'd7;
      cap_q   <= 1'b0;
      ready_q <= 1'b0;
      sdata_q <= 1'b0;
    end else begin
      sr_q    <= sr_d;
      nxt_q   <= nxt_d;
      carry_q <= carry_d;
      idx_q   <= idx_d;
      bit_q   <= bit_d;
      cap_q   <= rom_en;
      ready_q <= ready_d;
      sdata_q <= sdata_d;
    end
  end

  assign ready = ready_q;
  assign sdata = sdata_q;
endmodule

// File: rtl/serial_reg_programmer.sv
module serial_reg_programmer
  import sps_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ser_clk,
  output logic ser_data,
  output logic ser_load
);
  localparam logic [REG_W-1:0] LAST_REG = REG_W'(NUM_REGS - 1);

  seq_state_t        state_q, state_d;
  logic [REG_W-1:0]  reg_q, reg_d;
  logic [LEN_W-1:0]  bc_q, bc_d;
  logic              sclk_q, sclk_d;
  logic              load_q, load_d;
  logic              done_q, done_d;
  logic              half_q, half_d;
  logic              run, tick, fall, prime, ready;
  logic              rom_en;
  logic [IDX_W-1:0]  rom_idx;
  logic [BYTE_W-1:0] rom_q;
  logic [LEN_W-1:0]  flen;

  assign flen  = frame_len(reg_q);
  assign prime = (state_q == ST_PRIME);
  assign run   = (state_q == ST_SHIFT) || (state_q == ST_LATCH) || (state_q == ST_GAP);

  sps_tick_gen #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  sps_rom u_rom (
    .clk     (clk),
    .en      (rom_en),
    .reg_sel (reg_q),
    .idx     (rom_idx),
    .q       (rom_q)
  );

  sps_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_sel (reg_q),
    .prime   (prime),
    .fall    (fall),
    .rom_q   (rom_q),
    .rom_en  (rom_en),
    .rom_idx (rom_idx),
    .ready   (ready),
    .sdata   (ser_data)
  );

  always_comb begin
    state_d = state_q;
    reg_d   = reg_q;
    bc_d    = bc_q;
    sclk_d  = sclk_q;
    load_d  = load_q;
    half_d  = half_q;
    done_d  = 1'b0;
    fall    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          reg_d   = '0;
          state_d = ST_PRIME;
        end
      end
      ST_PRIME: begin
        bc_d    = '0;
        sclk_d  = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (ready) state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (tick) begin
          if (sclk_q) begin
            if (bc_q == flen) begin
              load_d  = 1'b1;
              half_d  = 1'b0;
              state_d = ST_LATCH;
            end else begin
              fall   = 1'b1;
              sclk_d = 1'b0;
              bc_d   = bc_q + 1'b1;
            end
          end else begin
            sclk_d = 1'b1;
          end
        end
      end
      ST_LATCH: begin
        if (tick) begin
          half_d = ~half_q;
          if (half_q) begin
            load_d = 1'b0;
            if (reg_q == LAST_REG) begin
              done_d  = 1'b1;
              state_d = ST_IDLE;
            end else begin
              state_d = ST_GAP;
            end
          end
        end
      end
      ST_GAP: begin
        if (tick) begin
          half_d = ~half_q;
          if (half_q) begin
            reg_d   = reg_q + 1'b1;
            state_d = ST_PRIME;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      reg_q   <= '0;
      bc_q    <= '0;
      sclk_q  <= 1'b1;
      load_q  <= 1'b0;
      done_q  <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      reg_q   <= reg_d;
      bc_q    <= bc_d;
      sclk_q  <= sclk_d;
      load_q  <= load_d;
      done_q  <= done_d;
      half_q  <= half_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign ser_clk  = sclk_q;
  assign ser_load = load_q;
endmodule

// File: rtl/sps_checker.sv
module sps_checker
  import sps_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic ser_clk,
  input logic ser_data,
  input logic ser_load
);
  localparam logic [15:0] GAP_MIN = 16'(2 * DIV);

  logic             sclk_p, load_p, data_p, busy_p;
  logic [LEN_W-1:0] rise_cnt;
  logic [REG_W-1:0] frame_cnt;
  logic [15:0]      idle_cnt;
  logic             first_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p     <= 1'b1;
      load_p     <= 1'b0;
      data_p     <= 1'b0;
      busy_p     <= 1'b0;
      rise_cnt   <= '0;
      frame_cnt  <= '0;
      idle_cnt   <= '0;
      first_pend <= 1'b0;
    end else begin
      sclk_p <= ser_clk;
      load_p <= ser_load;
      data_p <= ser_data;
      busy_p <= busy;
      if (start && !busy) begin
        rise_cnt  <= '0;
        frame_cnt <= '0;
      end else begin
        if (ser_load && !load_p)      rise_cnt <= '0;
        else if (ser_clk && !sclk_p)  rise_cnt <= rise_cnt + 1'b1;
        if (!ser_load && load_p)      frame_cnt <= frame_cnt + 1'b1;
      end
      if (!ser_load && load_p)        idle_cnt <= '0;
      else if (idle_cnt != 16'hFFFF)  idle_cnt <= idle_cnt + 1'b1;
      if (!ser_load && load_p)        first_pend <= 1'b1;
      else if (sclk_p && !ser_clk)    first_pend <= 1'b0;
    end
  end

  p_idle_outputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ser_clk && !ser_load));

  p_bit_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_load && !load_p) |-> (rise_cnt == frame_len(frame_cnt)));

  p_data_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_data != data_p) |-> (sclk_p && !ser_clk));

  p_load_clk_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_load |-> ser_clk);

  p_no_clk_in_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_load && load_p) |-> (ser_clk == sclk_p));

  p_load_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_load |-> busy);

  p_frame_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (first_pend && sclk_p && !ser_clk) |-> (idle_cnt >= GAP_MIN));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && busy_p) |-> done);
endmodule

bind serial_reg_programmer sps_checker #(.DIV(DIV)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .ser_clk  (ser_clk),
  .ser_data (ser_data),
  .ser_load (ser_load)
);

// File: tb/tb_serial_reg_programmer.sv
`timescale 1ns/1ps
module tb_serial_reg_programmer;
  localparam int unsigned DIV = 3;
  localparam int NREG = 8;
  // Expected frame length (5 + data bits) per register, walked in order.
  localparam int FLEN [NREG] = '{8, 207, 7, 35, 18, 30, 83, 70};

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic busy, done, ser_clk, ser_data, ser_load;

  always #2.5 clk = ~clk;

  serial_reg_programmer #(.DIV(DIV)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .ser_load (ser_load)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int r, input int b);
    int d;
    logic [7:0] by;
    if (b == 0) return 1'b0;
    if (b < 5) return ((r >> (b - 1)) & 1) != 0;
    d  = b - 5;
    by = 8'((r * 29 + (d / 8) * 13 + 60) % 256);
    return by[d % 8];
  endfunction

  // Monitor of the serial link, sampled on falling clock edges.
  logic mon_clr;
  int fr, nb, cyc_n, last_edge, load_rise_t, load_fall_t;
  int mism [NREG];
  int lens [NREG];
  int sw   [NREG];
  int min_half, max_half, min_gap;
  int clk_in_load, data_chg, done_cnt, done_long, busy_at_done, busy_err;
  logic sclk_p, load_p, data_p, done_p, busy_p;

  always @(negedge clk) begin
    if (mon_clr) begin
      fr = 0; nb = 0; cyc_n = 0; last_edge = -1; load_rise_t = 0; load_fall_t = 0;
      for (int i = 0; i < NREG; i++) begin
        mism[i] = 0; lens[i] = -1; sw[i] = -1;
      end
      min_half = 1000000; max_half = 0; min_gap = 1000000;
      clk_in_load = 0; data_chg = 0; done_cnt = 0; done_long = 0;
      busy_at_done = 0; busy_err = 0;
    end else begin
      cyc_n++;
      if (ser_clk && !sclk_p) begin
        if (ser_load) clk_in_load++;
        if (fr < NREG && ser_data !== exp_bit(fr, nb)) mism[fr]++;
        nb++;
        if (last_edge >= 0) begin
          if (cyc_n - last_edge < min_half) min_half = cyc_n - last_edge;
          if (cyc_n - last_edge > max_half) max_half = cyc_n - last_edge;
        end
        last_edge = cyc_n;
      end
      if (!ser_clk && sclk_p) begin
        if (ser_load) clk_in_load++;
        if (nb > 0) begin
          if (cyc_n - last_edge < min_half) min_half = cyc_n - last_edge;
          if (cyc_n - last_edge > max_half) max_half = cyc_n - last_edge;
        end else if (fr > 0) begin
          if (cyc_n - load_fall_t < min_gap) min_gap = cyc_n - load_fall_t;
        end
        last_edge = cyc_n;
      end
      if (ser_data !== data_p && !(sclk_p && !ser_clk)) data_chg++;
      if (ser_load && !load_p) begin
        if (fr < NREG) lens[fr] = nb;
        nb = 0;
        load_rise_t = cyc_n;
      end
      if (!ser_load && load_p) begin
        if (fr < NREG) sw[fr] = cyc_n - load_rise_t;
        fr++;
        load_fall_t = cyc_n;
      end
      if (done) begin
        done_cnt++;
        if (busy) busy_at_done++;
      end
      if (done && done_p) done_long++;
      if (!busy && busy_p && !done) busy_err++;
    end
    sclk_p = ser_clk;
    load_p = ser_load;
    data_p = ser_data;
    done_p = done;
    busy_p = busy;
  end

  task automatic clear_mon();
    @(negedge clk) mon_clr = 1'b1;
    @(negedge clk) mon_clr = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (done_cnt == 0 && n < 30000) begin
      @(negedge clk);
      n++;
    end
    repeat (4 * DIV) @(negedge clk);
  endtask

  task automatic wait_frames(input int k);
    int n = 0;
    while (fr < k && n < 30000) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic int total_mism();
    int s = 0;
    for (int i = 0; i < NREG; i++) s += mism[i];
    return s;
  endfunction

  // Watchdog
  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    mon_clr = 1'b1;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!busy && !done, "R1 busy/done in reset", {busy, done}, 0);
    check(ser_clk && !ser_load && !ser_data, "R1 link in reset",
          {ser_clk, ser_load, ser_data}, 4);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && ser_clk && !ser_load, "R1 idle after reset",
          {busy, ser_clk, ser_load}, 2);
    mon_clr = 1'b0;

    // Full sequence
    clear_mon();
    pulse_start();
    check(busy, "R9 busy after start", busy, 1);
    wait_done();
    for (int r = 0; r < NREG; r++) begin
      check(lens[r] == FLEN[r], $sformatf("R3 frame length reg %0d", r), lens[r], FLEN[r]);
      check(mism[r] == 0, $sformatf("R2 R11 bit errors reg %0d", r), mism[r], 0);
      check(sw[r] == 2 * DIV, $sformatf("R6 strobe width reg %0d", r), sw[r], 2 * DIV);
    end
    check(fr == NREG, "R8 frames sent", fr, NREG);
    check(done_cnt == 1 && done_long == 0, "R9 done pulse count", done_cnt, 1);
    check(busy_at_done == 0 && busy_err == 0, "R9 busy at end", busy_at_done + busy_err, 0);
    check(min_half == DIV && max_half == DIV, "R5 half period", min_half, DIV);
    check(min_gap >= 2 * DIV, "R7 frame gap", min_gap, 2 * DIV);
    check(data_chg == 0, "R4 data changes off falling edge", data_chg, 0);
    check(clk_in_load == 0, "R6 clock edges during strobe", clk_in_load, 0);
    check(!busy && ser_clk && !ser_load, "R1 idle after done",
          {busy, ser_clk, ser_load}, 2);

    // R10: start while busy is ignored
    clear_mon();
    pulse_start();
    wait_frames(2);
    pulse_start();
    wait_done();
    check(done_cnt == 1, "R10 single done", done_cnt, 1);
    check(fr == NREG, "R10 frame count", fr, NREG);
    check(total_mism() == 0, "R10 frame bits", total_mism(), 0);
    check(lens[NREG-1] == FLEN[NREG-1], "R10 last frame length", lens[NREG-1], FLEN[NREG-1]);

    // R12: reset in the middle of a sequence
    clear_mon();
    pulse_start();
    wait_frames(3);
    @(negedge clk) rst_n = 1'b0;
    #1;
    check(!busy && !ser_load && ser_clk && !done, "R12 outputs on reset",
          {busy, ser_load, ser_clk, done}, 2);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!busy && ser_clk && !ser_load, "R12 idle after release",
          {busy, ser_clk, ser_load}, 2);
    clear_mon();
    pulse_start();
    wait_done();
    check(fr == NREG && done_cnt == 1, "R12 rerun frames", fr, NREG);
    check(total_mism() == 0, "R12 rerun bits", total_mism(), 0);
    check(lens[1] == FLEN[1], "R12 rerun long frame", lens[1], FLEN[1]);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule